// File: doc/BRIEF.md
# DRAM Refresh and Power-On Sequencer

This block keeps an asynchronous DRAM alive without any help from the access controller beyond a bus grant. After reset it sits out a power-up pause of a set number of clock cycles. It then runs a fixed number of initialisation cycles. From that point it raises one refresh obligation per refresh interval, sized so that every row of the array is visited within the retention period. Each refresh is a CAS-before-RAS cycle. The device steps its own internal row counter, so the block drives no address and no data. It only sequences the two strobes.

The sequencer never takes the bus on its own. It holds a request high while work is owed and starts a strobe sequence on the first cycle that the controller grants. A saturating debt counter records refreshes that fell due but have not run yet. A flag warns when that backlog goes above a set limit.

The device loses its contents if no refresh completes for longer than the retention period. When that happens the sequencer treats it like a fresh power-up: it drops its ready indication, discards the debt and runs the pause and the initialisation cycles again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and on leaving it, `cas_n` and `ras_n` are 1, `ref_req` is 0, `init_done` is 0, `debt` is 0 and `debt_over` is 0.
- R2: After reset the block stays quiet for exactly PAUSE_CYC clock cycles: strobes high and `ref_req` low. `ref_req` is first seen high in the PAUSE_CYC-th cycle after reset is released.
- R3: A raised `ref_req` stays high, with both strobes high, for as long as `ref_gnt` is 0.
- R4: When `ref_req` and `ref_gnt` are both 1 at a clock edge, a refresh starts in the next cycle. First `cas_n` alone is 0 for CSR_CYC cycles. Then `cas_n` and `ras_n` are both 0 for RAS_CYC cycles. Then both strobes are 1 for at least PRE_CYC cycles before `cas_n` falls again. `ras_n` is never 0 while `cas_n` is 1.
- R5: After the pause, exactly INIT_CNT refresh cycles run. `init_done` rises at the clock edge that ends the precharge of the last of them.
- R6: While `init_done` is 1, `debt` rises by one every REF_INTERVAL cycles. The first rise is REF_INTERVAL cycles after `init_done` rose.
- R7: The end of a refresh that ran while `init_done` was 1 lowers `debt` by one. If that end falls in the same cycle as an interval rise, `debt` is left unchanged.
- R8: `debt` saturates at 2^DEBT_W-1 and does not wrap.
- R9: `debt_over` is 1 exactly when `debt` is greater than DEBT_LIMIT.
- R10: Suppose `init_done` is 1, no refresh is in progress, and no refresh has completed for RETAIN_CYC cycles. Then in the next cycle `init_done` falls, `debt` returns to 0 and `ref_req` is 0. The pause of R2 and the initialisation of R5 follow again.
- R11: While `init_done` is 1 and `debt` is 0, `ref_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh or initialisation cycle pending, bus wanted |
| ref_gnt | input | 1 | Controller hands the DRAM strobes to the sequencer |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| init_done | output | 1 | Pause and initialisation cycles complete |
| debt | output | DEBT_W | Number of interval refreshes owed |
| debt_over | output | 1 | Owed refreshes exceed DEBT_LIMIT |

## Verification
Two debt events can land on the same clock edge: the interval timer adding an owed refresh, and the strobe sequencer retiring one. The bench works out the edges of the interval schedule from the cycle at which `init_done` rose. It then pulses the grant exactly one refresh length before a scheduled rise, so that the precharge ends on that edge. The judgement is that `debt` reads the same value before and after the edge, where either event on its own would have moved it by one. A second coincidence is checked as well: the retention timeout fires on an interval edge, and the clear must win over the increment.

// File: rtl/drs_pkg.sv
package drs_pkg;

   typedef enum logic [1:0] {
      DRS_IDLE = 2'd0,
      DRS_CSET = 2'd1,
      DRS_RLOW = 2'd2,
      DRS_PREC = 2'd3
   } drs_state_e;

   function automatic int unsigned drs_max3(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/drs_cycle_timer.sv
module drs_cycle_timer #(
   parameter int unsigned LIMIT    = 4,
   parameter bit          SATURATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic hit
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] count;
   logic          at_end;

   assign at_end = (count == CW'(LIMIT - 1));
   assign hit    = run && at_end;

   if (LIMIT < 2) begin : g_bad_limit
      $error("drs_cycle_timer: LIMIT must be at least 2");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n || !run || clr) count <= '0;
         else if (!at_end)          count <= count + CW'(1);
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || !run || clr) count <= '0;
         else if (at_end)           count <= '0;
         else                       count <= count + CW'(1);
      end
   end
endmodule

// File: rtl/drs_debt_counter.sv
module drs_debt_counter #(
   parameter int unsigned DEBT_W     = 4,
   parameter int unsigned DEBT_LIMIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic              clr,
   output logic [DEBT_W-1:0] debt,
   output logic              over
);
   localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};

   if (DEBT_LIMIT >= (1 << DEBT_W) - 1) begin : g_bad_limit
      $error("drs_debt_counter: DEBT_LIMIT must be below the saturation value");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         debt <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (debt != DMAX) debt <= debt + DEBT_W'(1);
            2'b01:   if (debt != '0)   debt <= debt - DEBT_W'(1);
            default: debt <= debt;
         endcase
      end
   end

   assign over = (debt > DEBT_W'(DEBT_LIMIT));
endmodule

// File: rtl/drs_strobe_fsm.sv
module drs_strobe_fsm
   import drs_pkg::*;
#(
   parameter int unsigned CSR_CYC = 2,
   parameter int unsigned RAS_CYC = 7,
   parameter int unsigned PRE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic cas_n,
   output logic ras_n,
   output logic idle,
   output logic done
);
   localparam int unsigned MAXC = drs_max3(CSR_CYC, RAS_CYC, PRE_CYC);
   localparam int unsigned NW   = $clog2(MAXC + 1);

   if (CSR_CYC < 1 || RAS_CYC < 1 || PRE_CYC < 1) begin : g_bad_timing
      $error("drs_strobe_fsm: every phase needs at least one cycle");
   end

   drs_state_e    state;
   logic [NW-1:0] cnt;
   logic          csr_last, ras_last, pre_last;

   assign csr_last = (cnt == NW'(CSR_CYC - 1));
   assign ras_last = (cnt == NW'(RAS_CYC - 1));
   assign pre_last = (cnt == NW'(PRE_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= DRS_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            DRS_IDLE: begin
               cnt <= '0;
               if (start) state <= DRS_CSET;
            end
            DRS_CSET: begin
               if (csr_last) begin
                  state <= DRS_RLOW;
                  cnt   <= '0;
               end else cnt <= cnt + NW'(1);
            end
            DRS_RLOW: begin
               if (ras_last) begin
                  state <= DRS_PREC;
                  cnt   <= '0;
               end else cnt <= cnt + NW'(1);
            end
            default: begin
               if (pre_last) begin
                  state <= DRS_IDLE;
                  cnt   <= '0;
               end else cnt <= cnt + NW'(1);
            end
         endcase
      end
   end

   assign cas_n = !(state == DRS_CSET || state == DRS_RLOW);
   assign ras_n = (state != DRS_RLOW);
   assign idle  = (state == DRS_IDLE);
   assign done  = (state == DRS_PREC) && pre_last;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int unsigned PAUSE_CYC    = 25000,
   parameter int unsigned INIT_CNT     = 8,
   parameter int unsigned REF_INTERVAL = 1950,
   parameter int unsigned RETAIN_CYC   = 1000000,
   parameter int unsigned CSR_CYC      = 2,
   parameter int unsigned RAS_CYC      = 7,
   parameter int unsigned PRE_CYC      = 4,
   parameter int unsigned DEBT_W       = 4,
   parameter int unsigned DEBT_LIMIT   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ref_req,
   input  logic              ref_gnt,
   output logic              cas_n,
   output logic              ras_n,
   output logic              init_done,
   output logic [DEBT_W-1:0] debt,
   output logic              debt_over
);
   localparam int unsigned IW = $clog2(INIT_CNT + 1);

   if (INIT_CNT < 1) begin : g_bad_init
      $error("dram_refresh_seq: INIT_CNT must be at least 1");
   end
   if (RETAIN_CYC <= REF_INTERVAL) begin : g_bad_retain
      $error("dram_refresh_seq: RETAIN_CYC must exceed REF_INTERVAL");
   end

   logic          in_pause;
   logic [IW-1:0] init_left;
   logic          pause_end, tick, ret_expired;
   logic          fsm_idle, ref_done, restart, start;

   assign init_done = !in_pause && (init_left == '0);
   assign restart   = init_done && fsm_idle && ret_expired;
   assign ref_req   = !in_pause && fsm_idle && !restart &&
                      ((init_left != '0) || (debt != '0));
   assign start     = ref_req && ref_gnt;

   drs_cycle_timer #(.LIMIT(PAUSE_CYC), .SATURATE(1'b1)) u_pause (
      .clk(clk), .rst_n(rst_n), .run(in_pause), .clr(1'b0), .hit(pause_end));

   drs_cycle_timer #(.LIMIT(REF_INTERVAL), .SATURATE(1'b0)) u_interval (
      .clk(clk), .rst_n(rst_n), .run(init_done), .clr(1'b0), .hit(tick));

   drs_cycle_timer #(.LIMIT(RETAIN_CYC), .SATURATE(1'b1)) u_retain (
      .clk(clk), .rst_n(rst_n), .run(init_done), .clr(ref_done), .hit(ret_expired));

   drs_strobe_fsm #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .cas_n(cas_n), .ras_n(ras_n),
      .idle(fsm_idle), .done(ref_done));

   drs_debt_counter #(.DEBT_W(DEBT_W), .DEBT_LIMIT(DEBT_LIMIT)) u_debt (
      .clk(clk), .rst_n(rst_n), .inc(tick), .dec(ref_done && (init_left == '0)),
      .clr(restart), .debt(debt), .over(debt_over));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pause  <= 1'b1;
         init_left <= '0;
      end else if (restart) begin
         in_pause  <= 1'b1;
         init_left <= '0;
      end else if (pause_end) begin
         in_pause  <= 1'b0;
         init_left <= IW'(INIT_CNT);
      end else if (ref_done && (init_left != '0)) begin
         init_left <= init_left - IW'(1);
      end
   end
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int unsigned RAS_CYC    = 7,
   parameter int unsigned DEBT_W     = 4,
   parameter int unsigned DEBT_LIMIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cas_n,
   input logic              ras_n,
   input logic              ref_req,
   input logic              ref_gnt,
   input logic [DEBT_W-1:0] debt,
   input logic              debt_over,
   input logic              in_pause,
   input logic              restart
);
   logic [15:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      low_cnt <= '0;
      else if (!ras_n) low_cnt <= low_cnt + 16'd1;
      else             low_cnt <= '0;
   end

   AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);  // R4
   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));  // R4
   AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (low_cnt == 16'(RAS_CYC)));  // R4
   AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && ref_gnt) |=> (!cas_n && ras_n));  // R4
   AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_pause |-> (ras_n && cas_n && !ref_req));  // R2
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_gnt && !restart) |=> (ref_req || restart));  // R3
   AST_OVER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(debt_over) |-> (debt == DEBT_W'(DEBT_LIMIT + 1)));  // R9
   AST_DEBT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (debt != $past(debt)) |-> ((debt == $past(debt) + DEBT_W'(1)) ||
                                 (debt == $past(debt) - DEBT_W'(1)) || (debt == '0)));  // R8
endmodule

bind dram_refresh_seq drs_checker #(
   .RAS_CYC(RAS_CYC), .DEBT_W(DEBT_W), .DEBT_LIMIT(DEBT_LIMIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .ras_n(ras_n), .ref_req(ref_req),
   .ref_gnt(ref_gnt), .debt(debt), .debt_over(debt_over), .in_pause(in_pause),
   .restart(restart)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
   localparam int P  = 20;
   localparam int NI = 8;
   localparam int L  = 40;
   localparam int RT = 320;
   localparam int CS = 2;
   localparam int RS = 5;
   localparam int PR = 4;
   localparam int DW = 3;
   localparam int LM = 3;
   localparam int C  = CS + RS + PR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic ref_req, cas_n, ras_n, init_done, debt_over;
   logic [DW-1:0] debt;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int nref = 0;

   always #4 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   dram_refresh_seq #(.PAUSE_CYC(P), .INIT_CNT(NI), .REF_INTERVAL(L), .RETAIN_CYC(RT),
      .CSR_CYC(CS), .RAS_CYC(RS), .PRE_CYC(PR), .DEBT_W(DW), .DEBT_LIMIT(LM)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt), .cas_n(cas_n),
      .ras_n(ras_n), .init_done(init_done), .debt(debt), .debt_over(debt_over));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic wait_until(input int k);
      do @(negedge clk); while (cyc < k);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // strobe shape monitor
   int  m_csr = 0, m_ras = 0, m_gap = 0;
   logic pc = 1'b1, pr = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pc && !cas_n && nref > 0) chk(m_gap >= PR, "R4 precharge", m_gap, PR);
         if (pc && !cas_n) m_gap = 0;
         if (!cas_n && ras_n) m_csr++;
         if (!ras_n) m_ras++;
         if (cas_n && ras_n) m_gap++;
         if (!pr && ras_n) begin
            chk(m_csr == CS, "R4 cas lead", m_csr, CS);
            chk(m_ras == RS, "R4 ras width", m_ras, RS);
            chk(cas_n == 1'b1, "R4 cas release", int'(cas_n), 1);
            nref++;
            m_csr = 0;
            m_ras = 0;
         end
         pc = cas_n;
         pr = ras_n;
      end
   end

   initial begin
      while (cyc < 3000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int e0, e1, x, g, bad, first, n0;
      repeat (3) @(negedge clk);
      chk(cas_n && ras_n, "R1 strobes", int'({cas_n, ras_n}), 3);
      chk(!ref_req && !init_done, "R1 req/done", int'({ref_req, init_done}), 0);
      chk(debt == 0 && !debt_over, "R1 debt", int'(debt), 0);
      rst_n = 1'b1;

      // R2: quiet pause
      bad = 0; first = 0;
      while (first == 0) begin
         @(negedge clk);
         if (ref_req) first = cyc;
         else if (!cas_n || !ras_n) bad++;
      end
      chk(first == P, "R2 pause length", first, P);
      chk(bad == 0, "R2 strobes quiet", bad, 0);

      // R3: held request
      bad = 0;
      repeat (30) begin
         @(negedge clk);
         if (!ref_req || !cas_n || !ras_n) bad++;
      end
      chk(bad == 0, "R3 request held", bad, 0);

      // R5: initialisation
      ref_gnt = 1'b1;
      while (!init_done) @(negedge clk);
      e0 = cyc;
      ref_gnt = 1'b0;
      chk(nref == NI, "R5 init count", nref, NI);

      // R6 / R11
      wait_until(e0 + L - 1);
      chk(debt == 0 && !ref_req, "R11 no request", int'(ref_req), 0);
      wait_until(e0 + L);
      chk(debt == 1, "R6 first tick", int'(debt), 1);
      wait_until(e0 + 2 * L);
      chk(debt == 2, "R6 second tick", int'(debt), 2);

      // R7: completion on a tick edge
      g = e0 + 3 * L - C;
      wait_until(g - 1);
      ref_gnt = 1'b1;
      wait_until(g);
      ref_gnt = 1'b0;
      chk(!cas_n && ras_n, "R4 start", int'({cas_n, ras_n}), 1);
      wait_until(e0 + 3 * L - 1);
      chk(debt == 2, "R7 before coincidence", int'(debt), 2);
      wait_until(e0 + 3 * L);
      chk(debt == 2, "R7 coincident tick and completion", int'(debt), 2);

      // R9 boundary
      wait_until(e0 + 4 * L);
      chk(debt == LM && !debt_over, "R9 at limit", int'(debt_over), 0);
      wait_until(e0 + 5 * L);
      chk(debt == LM + 1 && debt_over, "R9 above limit", int'(debt_over), 1);

      // R8 saturation
      wait_until(e0 + 9 * L);
      chk(debt == 7, "R8 reach max", int'(debt), 7);
      wait_until(e0 + 10 * L);
      chk(debt == 7, "R8 saturated", int'(debt), 7);

      // R10 retention restart
      x = e0 + 3 * L + RT;
      wait_until(x - 1);
      chk(init_done && debt == 7, "R10 before timeout", int'(init_done), 1);
      wait_until(x);
      chk(!init_done && debt == 0 && !ref_req, "R10 restart", int'(debt), 0);
      wait_until(x + P - 1);
      chk(!ref_req, "R10 re-pause", int'(ref_req), 0);
      wait_until(x + P);
      chk(ref_req, "R10 re-pause end", int'(ref_req), 1);
      n0 = nref;
      ref_gnt = 1'b1;
      while (!init_done) @(negedge clk);
      e1 = cyc;
      chk(nref - n0 == NI, "R10 reinit count", nref - n0, NI);

      // R11 / R7 with the grant held
      wait_until(e1 + L - 1);
      chk(!ref_req && debt == 0, "R11 idle after init", int'(ref_req), 0);
      wait_until(e1 + L);
      chk(ref_req && debt == 1, "R6 tick after reinit", int'(debt), 1);
      wait_until(e1 + L + 1);
      chk(!cas_n, "R4 granted start", int'(cas_n), 0);
      wait_until(e1 + L + C);
      chk(debt == 1, "R7 before completion", int'(debt), 1);
      wait_until(e1 + L + C + 1);
      chk(debt == 0, "R7 completion", int'(debt), 0);
      finish_run();
   end
endmodule